// File: doc/BRIEF.md
# Multiplexed Acquisition Sequencer

This block times a multichannel data acquisition front end built from an analog multiplexer, a bank of sample-holds and a successive-approximation converter. It drives the multiplexer select, the sample/hold controls and a one-cycle converter launch strobe. It watches the converter's completion flag and hands out each converted word tagged with the channel it came from. The settling interval is a parameter counted in clock cycles. The conversion time belongs to the converter, and it is bounded by a second parameter that acts as a watchdog.

Two sweep modes are offered. In sequential mode each channel in turn tracks for the settling interval and is then frozen and converted. While that conversion runs, the multiplexer has already moved on to the next channel, so the next settling period can start the moment the result arrives. In simultaneous mode every sample-hold freezes on the same clock edge after one shared settling interval. The frozen values are then routed through the multiplexer to the converter one after another. At the end of a sweep the holds return to track, and the block either goes idle or starts a new sweep if the continuous input is high.

Top module: `acq_sequencer`

## Requirements
- R1: During and after reset, busy, every sh_hold bit, adc_start, result_valid and timeout_err are 0, and mux_sel is 0.
- R2: A start seen while idle with mode=0 (sequential) begins a sweep of channels 0..NUM_CH-1 in rising order. For each channel, mux_sel equals that channel and all sh_hold bits are 0 for exactly ACQ_CYCLES cycles. Then all sh_hold bits go to 1, and adc_start is 1 for that one cycle only.
- R3: In sequential mode, while channel c is being converted, mux_sel already shows (c+1) mod NUM_CH.
- R4: sh_hold stays all ones from the adc_start cycle up to and including the cycle in which adc_done is sampled high (or the watchdog expires). In sequential mode all bits fall in the next cycle.
- R5: With mode=1 (simultaneous), all sh_hold bits are 0 for ACQ_CYCLES cycles and then rise together on one edge; sh_hold is never a mix of 0 and 1. The bits stay high while channels 0..NUM_CH-1 are converted in order, with mux_sel equal to the channel under conversion. Each next adc_start comes in the cycle right after the previous adc_done.
- R6: In sequential mode, the spacing between successive adc_start pulses is exactly ACQ_CYCLES + D. D is the number of cycles from the adc_start cycle to the cycle in which adc_done is high, both counted. The spacing is never below ACQ_CYCLES + 1.
- R7: In the cycle after adc_done is sampled high during a conversion, result_valid is 1 for one cycle. result_chan then gives the converted channel, and result_data gives the adc_data value present with adc_done.
- R8: If adc_done has not been high within CONV_TIMEOUT cycles, counted from the adc_start cycle inclusive, then in the next cycle timeout_err is 1, busy is 0, sh_hold is 0 and mux_sel is 0. A done in cycle CONV_TIMEOUT is still accepted. timeout_err holds until the next accepted start clears it.
- R9: continuous is sampled when the last channel's done arrives. If it is 0, the block goes idle with busy 0, sh_hold 0 and mux_sel 0. If it is 1, a new sweep starts at channel 0 with a fresh settling interval.
- R10: start and mode are ignored while busy is high, and adc_done is ignored while no conversion is running (no result_valid follows).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sweep when idle |
| mode | input | 1 | 0 sequential, 1 simultaneous; taken at start |
| continuous | input | 1 | Restart a new sweep after the last channel |
| adc_done | input | 1 | Converter completion pulse |
| adc_data | input | DATA_W | Converter output word, valid with adc_done |
| busy | output | 1 | Sweep in progress |
| mux_sel | output | CH_W | Multiplexer channel select |
| sh_hold | output | NUM_CH | Per-channel hold control, 1 = hold, 0 = track |
| adc_start | output | 1 | One-cycle conversion launch |
| result_valid | output | 1 | Result strobe |
| result_chan | output | CH_W | Channel tag of the result |
| result_data | output | DATA_W | Converted word |
| timeout_err | output | 1 | Converter watchdog expired |

## Verification
The properties assume that the converter answers each launch with at most one single-cycle adc_done, and that mode changes only while the block is idle; the spacing property reads the live mode pin. The converter model in the bench answers each launch once, with a programmed delay of 1 to CONV_TIMEOUT cycles, or never for the watchdog case. It changes mode only between sweeps, except in the one test that toggles it mid-sweep to show it is ignored, where the spacing property is simply not enabled. The model returns a value that depends on the channel and the cycle of the freeze, so a wrong select or a misplaced hold shows up in result_data.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_TRACK = 2'd1,
    SEQ_CONV  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/acq_down_timer.sv
// Loadable down-counter; zero marks the final cycle of an interval.
module acq_down_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load | (en & (cnt_q != '0));

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/acq_chan_step.sv
// Next channel in a sweep with wrap, and last-channel flag.
module acq_chan_step #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic [CH_W-1:0] chan,
  output logic [CH_W-1:0] chan_next,
  output logic            chan_last
);
  assign chan_last = (chan == CH_W'(NUM_CH - 1));
  assign chan_next = chan_last ? '0 : chan + 1'b1;
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer #(
  parameter int NUM_CH       = 4,
  parameter int DATA_W       = 12,
  parameter int ACQ_CYCLES   = 5,
  parameter int CONV_TIMEOUT = 20,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode,
  input  logic              continuous,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  output logic              busy,
  output logic [CH_W-1:0]   mux_sel,
  output logic [NUM_CH-1:0] sh_hold,
  output logic              adc_start,
  output logic              result_valid,
  output logic [CH_W-1:0]   result_chan,
  output logic [DATA_W-1:0] result_data,
  output logic              timeout_err
);
  import acq_seq_pkg::*;

  localparam int ACQ_W = $clog2(ACQ_CYCLES + 1);
  localparam int TO_W  = $clog2(CONV_TIMEOUT + 1);

  seq_state_e        state_q, state_d;
  logic [CH_W-1:0]   chan_q, chan_d;
  logic              simul_q, simul_d;
  logic              launch_q, launch_d;
  logic              rv_q, rv_d;
  logic [CH_W-1:0]   rchan_q, rchan_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              err_q, err_d;
  logic              acq_load, acq_zero, to_load, to_zero;
  logic [CH_W-1:0]   chan_next;
  logic              chan_last;
  logic              in_track, in_conv;
  logic              ctx_en;

  assign in_track = (state_q == SEQ_TRACK);
  assign in_conv  = (state_q == SEQ_CONV);

  acq_chan_step #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_step (
    .chan(chan_q), .chan_next(chan_next), .chan_last(chan_last)
  );

  acq_down_timer #(.W(ACQ_W)) u_acq_tmr (
    .clk(clk), .rst_n(rst_n), .load(acq_load),
    .load_val(ACQ_W'(ACQ_CYCLES - 1)), .en(in_track), .zero(acq_zero)
  );

  acq_down_timer #(.W(TO_W)) u_conv_wdog (
    .clk(clk), .rst_n(rst_n), .load(to_load),
    .load_val(TO_W'(CONV_TIMEOUT - 1)), .en(in_conv), .zero(to_zero)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    chan_d   = chan_q;
    simul_d  = simul_q;
    launch_d = 1'b0;
    rv_d     = 1'b0;
    rchan_d  = rchan_q;
    rdata_d  = rdata_q;
    err_d    = err_q;
    acq_load = 1'b0;
    to_load  = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_d  = SEQ_TRACK;
          chan_d   = '0;
          simul_d  = mode;
          err_d    = 1'b0;
          acq_load = 1'b1;
        end
      end
      SEQ_TRACK: begin
        if (acq_zero) begin
          state_d  = SEQ_CONV;
          launch_d = 1'b1;
          to_load  = 1'b1;
        end
      end
      SEQ_CONV: begin
        if (adc_done) begin
          rv_d    = 1'b1;
          rchan_d = chan_q;
          rdata_d = adc_data;
          chan_d  = chan_next;
          if (chan_last) begin
            if (continuous) begin
              state_d  = SEQ_TRACK;
              acq_load = 1'b1;
            end else begin
              state_d = SEQ_IDLE;
            end
          end else if (simul_q) begin
            launch_d = 1'b1;
            to_load  = 1'b1;
          end else begin
            state_d  = SEQ_TRACK;
            acq_load = 1'b1;
          end
        end else if (to_zero) begin
          state_d = SEQ_IDLE;
          chan_d  = '0;
          err_d   = 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  assign ctx_en = (state_q != state_d) || (chan_q != chan_d) || (simul_q != simul_d);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      chan_q  <= '0;
      simul_q <= 1'b0;
    end else if (ctx_en) begin
      state_q <= state_d;
      chan_q  <= chan_d;
      simul_q <= simul_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      launch_q <= 1'b0;
      rv_q     <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      launch_q <= launch_d;
      rv_q     <= rv_d;
      err_q    <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rchan_q <= '0;
      rdata_q <= '0;
    end else if (rv_d) begin
      rchan_q <= rchan_d;
      rdata_q <= rdata_d;
    end
  end

  // outputs
  assign busy         = (state_q != SEQ_IDLE);
  assign sh_hold      = {NUM_CH{in_conv}};
  assign mux_sel      = (in_conv && !simul_q) ? chan_next : chan_q;
  assign adc_start    = launch_q;
  assign result_valid = rv_q;
  assign result_chan  = rchan_q;
  assign result_data  = rdata_q;
  assign timeout_err  = err_q;
endmodule

// File: rtl/acq_sequencer_chk.sv
module acq_sequencer_chk #(
  parameter int NUM_CH     = 4,
  parameter int ACQ_CYCLES = 5,
  parameter int CH_W       = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode,
  input logic              adc_done,
  input logic              busy,
  input logic [CH_W-1:0]   mux_sel,
  input logic [NUM_CH-1:0] sh_hold,
  input logic              adc_start,
  input logic              result_valid,
  input logic              timeout_err
);
  localparam int GAP_W   = $clog2(ACQ_CYCLES + 2) + 1;
  localparam int GAP_MIN = ACQ_CYCLES + 1;

  logic [GAP_W-1:0] gap_q;
  logic             seen_q;
  logic             all_hold;

  assign all_hold = &sh_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (adc_start) begin
      gap_q  <= GAP_W'(1);
      seen_q <= 1'b1;
    end else if (gap_q < GAP_W'(GAP_MIN)) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sh_hold == '0) && (mux_sel == '0) && !adc_start);

  assert_launch_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  assert_launch_in_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> all_hold);

  assert_hold_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (all_hold && !adc_done) |=> (all_hold || timeout_err));

  assert_hold_uniform_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_hold == '0) || all_hold);

  assert_min_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_start && seen_q && !mode) |-> (gap_q >= GAP_W'(GAP_MIN)));

  assert_result_follows_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_done && all_hold) |=> result_valid);

  assert_timeout_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> !busy);

  assert_stray_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_done && !all_hold) |=> !result_valid);
endmodule

bind acq_sequencer acq_sequencer_chk #(
  .NUM_CH(NUM_CH), .ACQ_CYCLES(ACQ_CYCLES), .CH_W(CH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .adc_done(adc_done), .busy(busy),
  .mux_sel(mux_sel), .sh_hold(sh_hold), .adc_start(adc_start),
  .result_valid(result_valid), .timeout_err(timeout_err)
);

// File: tb/tb_acq_sequencer.sv
module tb_acq_sequencer;
  localparam int NUM_CH = 4;
  localparam int DATA_W = 12;
  localparam int ACQ    = 5;
  localparam int TMO    = 20;
  localparam int CH_W   = 2;

  typedef struct packed {
    logic       simul;
    logic       cont;
    logic [7:0] dly;
    logic [7:0] nres;
  } vec_t;

  // simul, cont, converter delay, expected results
  localparam vec_t VEC [6] = '{
    '{1'b0, 1'b0, 8'd3,   8'd4},
    '{1'b0, 1'b0, 8'd1,   8'd4},
    '{1'b1, 1'b0, 8'd4,   8'd4},
    '{1'b1, 1'b1, 8'd2,   8'd8},
    '{1'b0, 1'b1, 8'd6,   8'd8},
    '{1'b0, 1'b0, 8'(TMO), 8'd4}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic start, mode, continuous, adc_done;
  logic [DATA_W-1:0] adc_data;
  logic busy, adc_start, result_valid, timeout_err;
  logic [CH_W-1:0] mux_sel, result_chan;
  logic [NUM_CH-1:0] sh_hold;
  logic [DATA_W-1:0] result_data;

  always #4 clk = ~clk;

  acq_sequencer #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ACQ_CYCLES(ACQ),
                  .CONV_TIMEOUT(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .continuous(continuous),
    .adc_done(adc_done), .adc_data(adc_data), .busy(busy), .mux_sel(mux_sel),
    .sh_hold(sh_hold), .adc_start(adc_start), .result_valid(result_valid),
    .result_chan(result_chan), .result_data(result_data), .timeout_err(timeout_err)
  );

  int checks = 0;
  int errs   = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [DATA_W-1:0] ana(input int k, input int t);
    return DATA_W'((k << 8) | (t & 255));
  endfunction

  // converter model and monitor state
  int   run_dly   = 3;
  logic run_simul = 1'b0;
  logic stray_req = 1'b0;
  int   cnt = 0, frz_t = 0, last_frz = 0, track_sel = 0, track_cnt = 0;
  logic prev_hold = 1'b0;
  logic [DATA_W-1:0] pend;
  int   n_starts = 0, res_idx = 0, last_start = 0, bad_hold = 0;

  always @(negedge clk) begin
    adc_done = 1'b0;
    if (stray_req) begin adc_done = 1'b1; adc_data = '1; stray_req = 1'b0; end
    if (rst_n) begin
      if (sh_hold != '0 && sh_hold != '1) bad_hold++;
      if (sh_hold != '0 && !prev_hold) frz_t = cyc;
      prev_hold = (sh_hold != '0);
      if (sh_hold == '0) track_sel = int'(mux_sel);
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin adc_done = 1'b1; adc_data = pend; end
      end
      if (adc_start) begin
        pend = ana(run_simul ? int'(mux_sel) : track_sel, frz_t);
        last_frz = frz_t;
        if (run_dly == 1) begin adc_done = 1'b1; adc_data = pend; end
        else if (run_dly > 1) cnt = run_dly - 1;
        // monitor
        check(sh_hold == '1, "R4 hold at launch", int'(sh_hold), 15);
        if (run_simul)
          check(int'(mux_sel) == n_starts % NUM_CH, "R5 select during conversion",
                int'(mux_sel), n_starts % NUM_CH);
        else
          check(int'(mux_sel) == (n_starts + 1) % NUM_CH, "R3 next channel preselected",
                int'(mux_sel), (n_starts + 1) % NUM_CH);
        if (track_cnt != 0)
          check(track_cnt == ACQ, "R2 settling cycles", track_cnt, ACQ);
        if (n_starts > 0 && run_dly > 0) begin
          if (!run_simul)
            check(cyc - last_start == ACQ + run_dly, "R6 launch spacing",
                  cyc - last_start, ACQ + run_dly);
          else if (n_starts % NUM_CH != 0)
            check(cyc - last_start == run_dly, "R5 back-to-back launch",
                  cyc - last_start, run_dly);
        end
        last_start = cyc;
        n_starts++;
      end
      if (busy && sh_hold == '0) track_cnt++; else track_cnt = 0;
      if (result_valid) begin
        check(int'(result_chan) == res_idx % NUM_CH, "R7 result tag",
              int'(result_chan), res_idx % NUM_CH);
        check(result_data == ana(res_idx % NUM_CH, last_frz), "R7 result data",
              int'(result_data), int'(ana(res_idx % NUM_CH, last_frz)));
        res_idx++;
      end
    end
  end

  task automatic wait_idle(input string tag);
    int n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
    check(!busy, tag, int'(busy), 0);
  endtask

  task automatic kick(input logic m, input logic c, input int d);
    @(negedge clk);
    run_dly = d; run_simul = m; n_starts = 0; res_idx = 0; bad_hold = 0;
    start = 1'b1; mode = m; continuous = c;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; mode = 1'b0; continuous = 1'b0;
    adc_done = 1'b0; adc_data = '0;
    repeat (3) @(negedge clk);
    check(!busy && sh_hold == '0 && mux_sel == '0 && !adc_start && !result_valid
          && !timeout_err, "R1 reset state", int'(sh_hold), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && sh_hold == '0 && mux_sel == '0, "R1 after release", int'(busy), 0);

    // vector table
    for (int i = 0; i < 6; i++) begin
      kick(VEC[i].simul, VEC[i].cont, int'(VEC[i].dly));
      if (VEC[i].cont) begin
        for (int n = 0; n < 2000 && res_idx < NUM_CH + 1; n++) @(negedge clk);
        continuous = 1'b0;
      end
      wait_idle("R9 sweep ends idle");
      @(posedge clk);
      check(res_idx == int'(VEC[i].nres), "R9 result count", res_idx, int'(VEC[i].nres));
      check(bad_hold == 0, "R5 holds uniform", bad_hold, 0);
      check(!timeout_err, "R8 no error on accepted done", int'(timeout_err), 0);
      @(negedge clk);
      check(sh_hold == '0 && mux_sel == '0, "R9 released at end", int'(sh_hold), 0);
    end

    // watchdog expiry
    begin
      int t0 = 0, n = 0;
      kick(1'b0, 1'b0, 0);
      while (!adc_start && n < 200) begin @(negedge clk); n++; end
      t0 = cyc;
      n = 0;
      while (busy && n < 200) begin @(negedge clk); n++; end
      check(cyc - t0 == TMO, "R8 expiry cycle", cyc - t0, TMO);
      check(timeout_err == 1'b1, "R8 error flag", int'(timeout_err), 1);
      check(sh_hold == '0 && mux_sel == '0, "R8 released on expiry", int'(sh_hold), 0);
      repeat (3) @(negedge clk);
      check(timeout_err == 1'b1, "R8 error holds", int'(timeout_err), 1);
      check(res_idx == 0, "R8 no result", res_idx, 0);
    end

    // start clears error; start and mode ignored while busy
    kick(1'b0, 1'b0, 2);
    check(timeout_err == 1'b0, "R8 cleared by start", int'(timeout_err), 0);
    repeat (8) @(negedge clk);
    start = 1'b1; mode = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle("R10 sweep completes");
    mode = 1'b0;
    @(posedge clk);
    check(res_idx == NUM_CH, "R10 start while busy ignored", res_idx, NUM_CH);
    check(bad_hold == 0, "R10 mode while busy ignored", bad_hold, 0);

    // stray done while idle
    @(negedge clk);
    stray_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!result_valid && !busy, "R10 stray done ignored", int'(result_valid), 0);
    check(res_idx == NUM_CH, "R10 no stray result", res_idx, NUM_CH);

    // reset in mid-sweep
    kick(1'b1, 1'b0, 4);
    repeat (ACQ + 2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!busy && sh_hold == '0 && mux_sel == '0 && !adc_start, "R1 reset mid-sweep",
          int'(sh_hold), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule